// File: doc/BRIEF.md
# Outbound Configuration Address Translator

This block sits between a CPU-side address bus and a PCIe root port. It takes 32-bit addresses from a configuration aperture and turns them into 64-bit configuration request addresses. With each address it gives the request kind, configuration type 0 or type 1. Translation is done by a small set of outbound windows. Each window has a base, an inclusive limit, a 64-bit target, a request-kind field and an enable. The windows are programmed through a banked register port: a selector register picks which window the following register writes land in.

Out of reset the windows are already laid out as a configuration aperture. The top 1 MB of the 16 MB outbound area is split into four 256 KB slices. The last slice is cut short by 16 KB, which is kept free for local registers. Slice *i* targets bus *i+1*: the bus number sits in target bits [31:24] and device/function in bits [23:16]. The first slice issues type 0 requests and the others issue type 1. An address that no enabled window claims is flagged as a miss and passed through unchanged.

Top module: `cfgx_xlate_top`

## Requirements
- R1: While reset is asserted and in the cycle after it ends, `res_valid` and `res_miss` are 0.
- R2: After reset, window 0 covers 0x01F00000..0x01F3FFFF. It maps an address A to 0x01000000 + (A − 0x01F00000) with kind 4 (config type 0).
- R3: After reset, windows 1, 2 and 3 start at 0x01F40000, 0x01F80000 and 0x01FC0000. They target buses 2, 3 and 4 (bus number at bits [31:24]) with kind 5 (config type 1).
- R4: The reset limit of window 3 is 0x01FFBFFF. Address 0x01FFC000 is a miss.
- R5: On a miss, `res_miss` is 1, `res_addr` equals the input address zero-extended to 64 bits, and `res_kind` is 0 (memory).
- R6: Every accepted input (`xl_valid`=1) produces exactly one result with `res_valid`=1 on the next clock edge, and there are no other results.
- R7: Register word index 0 is the window selector. The indices of the selected window are: 1 = control 1 (request kind in bits [4:0]), 2 = control 2, 3 = base low, 4 = base high, 5 = limit, 6 = target low, 7 = target high. Target high appears in `res_addr[63:32]`.
- R8: Control 2 bit 31 enables the window. A window written with bit 31 clear never hits.
- R9: When several enabled windows match, the lowest-numbered one is used.
- R10: While the selector holds a value not below the number of windows, writes to indices 1..7 change no window.
- R11: A window whose base-high register is nonzero never matches a 32-bit input address.
- R12: Both bounds are inclusive: an address equal to the base or to the limit hits, and one below the base misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_idx | input | 3 | Register word index (byte offset / 4) |
| cfg_wr_data | input | 32 | Register write data |
| xl_valid | input | 1 | Address to translate is present |
| xl_addr | input | 32 | CPU-side address |
| res_valid | output | 1 | Result present |
| res_addr | output | 64 | Translated (or passed-through) address |
| res_kind | output | 5 | Request kind: 0 mem, 1 locked mem read, 2 I/O, 4 cfg type 0, 5 cfg type 1 |
| res_miss | output | 1 | No enabled window claimed the address |

## Verification
The reset layout is tested at each window base, at an interior offset, at the exact limits, and just past the shortened last window and just below the first. These addresses separate off-by-one bound errors, a missing 16 KB cut, and wrong bus or type assignments. After that, windows are reprogrammed to create overlap, a disabled window, a nonzero target high, and a nonzero base high. Writes are also made while the selector is out of range. Each of these shows whether priority, enable, 64-bit target arithmetic and write gating act on the intended window. Back-to-back and gapped address streams check, by cycle number, that results come out one per input and one cycle late.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

   localparam int DW = 32;

   // request kind encodings carried in control 1 bits [4:0]
   localparam logic [4:0] RQ_MEM      = 5'd0;
   localparam logic [4:0] RQ_MEM_LOCK = 5'd1;
   localparam logic [4:0] RQ_IO       = 5'd2;
   localparam logic [4:0] RQ_CFG0     = 5'd4;
   localparam logic [4:0] RQ_CFG1     = 5'd5;

   // register word indices; the selector must stay at index 0
   localparam logic [2:0] IX_SEL  = 3'd0;
   localparam logic [2:0] IX_CTL1 = 3'd1;
   localparam logic [2:0] IX_CTL2 = 3'd2;
   localparam logic [2:0] IX_BLO  = 3'd3;
   localparam logic [2:0] IX_BHI  = 3'd4;
   localparam logic [2:0] IX_LIM  = 3'd5;
   localparam logic [2:0] IX_TLO  = 3'd6;
   localparam logic [2:0] IX_THI  = 3'd7;

   localparam int EN_BIT = 31;

   typedef struct packed {
      logic [DW-1:0] base_lo;
      logic [DW-1:0] base_hi;
      logic [DW-1:0] limit;
      logic [DW-1:0] tgt_lo;
      logic [DW-1:0] tgt_hi;
      logic [4:0]    kind;
      logic          en;
   } win_cfg_t;

   // reset layout of one window inside the configuration aperture
   function automatic win_cfg_t preset_win(int unsigned idx, int unsigned n_win,
                                           logic [DW-1:0] ap_end, logic [DW-1:0] ap_span,
                                           logic [DW-1:0] hole);
      win_cfg_t      w;
      logic [DW-1:0] step;
      logic [DW-1:0] b;
      step      = ap_span / DW'(n_win);
      b         = ap_end - ap_span + DW'(idx) * step;
      w.base_lo = b;
      w.base_hi = '0;
      w.limit   = b + step - 1 - ((idx == n_win - 1) ? hole : '0);
      w.tgt_lo  = DW'(idx + 1) << 24;
      w.tgt_hi  = '0;
      w.kind    = (idx == 0) ? RQ_CFG0 : RQ_CFG1;
      w.en      = 1'b1;
      return w;
   endfunction

endpackage

// File: rtl/cfgx_regfile.sv
module cfgx_regfile
   import cfgx_pkg::*;
#(
   parameter int            N_WIN      = 4,
   parameter bit            PRESET     = 1'b1,
   parameter logic [31:0]   AREA_BASE  = 32'h0100_0000,
   parameter logic [31:0]   AREA_SIZE  = 32'h0100_0000,
   parameter logic [31:0]   AP_SPAN    = 32'h0010_0000,
   parameter logic [31:0]   LOCAL_HOLE = 32'h0000_4000
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [2:0]              wr_idx,
   input  logic [DW-1:0]           wr_data,
   output win_cfg_t [N_WIN-1:0]    cfg_o
);

   localparam logic [31:0] AP_END = AREA_BASE + AREA_SIZE;

   logic [DW-1:0] sel_q;
   logic          bank_wr;

   assign bank_wr = wr_en && (wr_idx != IX_SEL);

   always_ff @(posedge clk) begin
      if (!rst_n)
         sel_q <= '0;
      else if (wr_en && (wr_idx == IX_SEL))
         sel_q <= wr_data;
   end

   for (genvar g = 0; g < N_WIN; g++) begin : g_win
      win_cfg_t rst_val;
      win_cfg_t w_q;
      logic     mine;

      if (PRESET) begin : g_preset
         assign rst_val = preset_win(g, N_WIN, AP_END, AP_SPAN, LOCAL_HOLE);
      end else begin : g_blank
         assign rst_val = '0;
      end

      assign mine = bank_wr && (sel_q == DW'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            w_q <= rst_val;
         end else if (mine) begin
            case (wr_idx)
               IX_CTL1: w_q.kind    <= wr_data[4:0];
               IX_CTL2: w_q.en      <= wr_data[EN_BIT];
               IX_BLO:  w_q.base_lo <= wr_data;
               IX_BHI:  w_q.base_hi <= wr_data;
               IX_LIM:  w_q.limit   <= wr_data;
               IX_TLO:  w_q.tgt_lo  <= wr_data;
               IX_THI:  w_q.tgt_hi  <= wr_data;
               default: w_q         <= w_q;
            endcase
         end
      end

      assign cfg_o[g] = w_q;
   end

   logic unused_ctl_bits;
   assign unused_ctl_bits = ^wr_data[EN_BIT-1:5];

   // R10
   sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_wr && (sel_q >= DW'(N_WIN))) |=> $stable(cfg_o))
      else $error("window changed while selector out of range");

endmodule

// File: rtl/cfgx_win_match.sv
module cfgx_win_match
   import cfgx_pkg::*;
(
   input  win_cfg_t        cfg,
   input  logic [DW-1:0]   addr,
   output logic            hit,
   output logic [2*DW-1:0] xaddr
);

   logic          in_range;
   logic [DW-1:0] offset;

   assign in_range = (addr >= cfg.base_lo) && (addr <= cfg.limit) && (cfg.base_hi == '0);
   assign hit      = cfg.en && in_range;
   assign offset   = addr - cfg.base_lo;
   assign xaddr    = {cfg.tgt_hi, cfg.tgt_lo} + {{DW{1'b0}}, offset};

endmodule

// File: rtl/cfgx_pick.sv
module cfgx_pick
   import cfgx_pkg::*;
#(
   parameter int N_WIN = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [N_WIN-1:0]            hit,
   input  logic [N_WIN-1:0][2*DW-1:0]  xaddr,
   input  logic [N_WIN-1:0][4:0]       kind,
   output logic                        any_hit,
   output logic [2*DW-1:0]             sel_addr,
   output logic [4:0]                  sel_kind
);

   logic [N_WIN-1:0] grant;

   // isolate the lowest set bit: lowest index wins
   assign grant   = hit & (~hit + N_WIN'(1));
   assign any_hit = |hit;

   always_comb begin
      sel_addr = '0;
      sel_kind = '0;
      for (int i = 0; i < N_WIN; i++) begin
         sel_addr = sel_addr | (xaddr[i] & {(2*DW){grant[i]}});
         sel_kind = sel_kind | (kind[i]  & {5{grant[i]}});
      end
   end

   // R9
   one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && ((grant & ~hit) == '0) && (any_hit == (grant != '0)))
      else $error("priority grant malformed");

endmodule

// File: rtl/cfgx_xlate_top.sv
module cfgx_xlate_top
   import cfgx_pkg::*;
#(
   parameter int            N_WIN      = 4,
   parameter bit            PRESET     = 1'b1,
   parameter logic [31:0]   AREA_BASE  = 32'h0100_0000,
   parameter logic [31:0]   AREA_SIZE  = 32'h0100_0000,
   parameter logic [31:0]   AP_SPAN    = 32'h0010_0000,
   parameter logic [31:0]   LOCAL_HOLE = 32'h0000_4000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_wr_en,
   input  logic [2:0]  cfg_wr_idx,
   input  logic [31:0] cfg_wr_data,
   input  logic        xl_valid,
   input  logic [31:0] xl_addr,
   output logic        res_valid,
   output logic [63:0] res_addr,
   output logic [4:0]  res_kind,
   output logic        res_miss
);

   initial begin : param_chk
      assert (N_WIN >= 1 && N_WIN <= 16) else $error("N_WIN out of range");
      assert (AP_SPAN <= AREA_SIZE) else $error("aperture larger than area");
      assert ((AP_SPAN % N_WIN) == 0) else $error("aperture not divisible");
      assert (LOCAL_HOLE < AP_SPAN / N_WIN) else $error("hole too large");
   end

   win_cfg_t [N_WIN-1:0]           cfg;
   logic [N_WIN-1:0]               hit;
   logic [N_WIN-1:0][2*DW-1:0]     xaddr;
   logic [N_WIN-1:0][4:0]          kind;
   logic                           any_hit;
   logic [2*DW-1:0]                sel_addr;
   logic [4:0]                     sel_kind;

   cfgx_regfile #(
      .N_WIN(N_WIN), .PRESET(PRESET), .AREA_BASE(AREA_BASE),
      .AREA_SIZE(AREA_SIZE), .AP_SPAN(AP_SPAN), .LOCAL_HOLE(LOCAL_HOLE)
   ) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_idx(cfg_wr_idx),
      .wr_data(cfg_wr_data), .cfg_o(cfg)
   );

   for (genvar g = 0; g < N_WIN; g++) begin : g_match
      cfgx_win_match match_i (
         .cfg(cfg[g]), .addr(xl_addr), .hit(hit[g]), .xaddr(xaddr[g])
      );
      assign kind[g] = cfg[g].kind;
   end

   cfgx_pick #(.N_WIN(N_WIN)) pick_i (
      .clk(clk), .rst_n(rst_n), .hit(hit), .xaddr(xaddr), .kind(kind),
      .any_hit(any_hit), .sel_addr(sel_addr), .sel_kind(sel_kind)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_miss  <= 1'b0;
         res_addr  <= '0;
         res_kind  <= RQ_MEM;
      end else begin
         res_valid <= xl_valid;
         if (xl_valid) begin
            res_miss <= !any_hit;
            res_addr <= any_hit ? sel_addr : {{DW{1'b0}}, xl_addr};
            res_kind <= any_hit ? sel_kind : RQ_MEM;
         end
      end
   end

   // R6
   one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xl_valid |=> res_valid)
      else $error("result missing one cycle after input");

   // R6
   no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !xl_valid |=> !res_valid)
      else $error("result without input");

   // R5
   miss_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_miss) |-> (res_addr == {32'b0, $past(xl_addr)} && res_kind == RQ_MEM))
      else $error("miss did not pass address through");

endmodule

// File: tb/cfgx_xlate_top_tb_top.sv
module cfgx_xlate_top_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [2:0]  cfg_wr_idx = '0;
   logic [31:0] cfg_wr_data = '0;
   logic        xl_valid = 1'b0;
   logic [31:0] xl_addr = '0;
   logic        res_valid;
   logic [63:0] res_addr;
   logic [4:0]  res_kind;
   logic        res_miss;

   always #10 clk = ~clk;

   cfgx_xlate_top dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx),
      .cfg_wr_data(cfg_wr_data), .xl_valid(xl_valid), .xl_addr(xl_addr),
      .res_valid(res_valid), .res_addr(res_addr), .res_kind(res_kind), .res_miss(res_miss)
   );

   typedef struct {
      int          cyc;
      logic [63:0] addr;
      logic [4:0]  kind;
      logic        miss;
      string       req;
   } exp_t;

   exp_t queue_q[$];
   int   cyc = 0;
   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: pop expected item on each result
   always @(negedge clk) begin
      if (rst_n && res_valid) begin
         checks++;
         if (queue_q.size() == 0) begin
            errors++;
            $display("FAIL R6 unexpected result addr=%h (expected none)", res_addr);
         end else begin
            exp_t e;
            e = queue_q.pop_front();
            if (cyc != e.cyc || res_addr !== e.addr || res_kind !== e.kind || res_miss !== e.miss) begin
               errors++;
               $display("FAIL %s cyc=%0d addr=%h kind=%0d miss=%b expected cyc=%0d addr=%h kind=%0d miss=%b",
                        e.req, cyc, res_addr, res_kind, res_miss, e.cyc, e.addr, e.kind, e.miss);
            end
         end
      end
   end

   task automatic send(input logic [31:0] a, input logic [63:0] ea,
                       input logic [4:0] ek, input logic em, input string req);
      exp_t e;
      @(negedge clk);
      xl_valid = 1'b1;
      xl_addr  = a;
      e.cyc = cyc + 1; e.addr = ea; e.kind = ek; e.miss = em; e.req = req;
      queue_q.push_back(e);
   endtask

   task automatic quiet();
      @(negedge clk);
      xl_valid  = 1'b0;
      cfg_wr_en = 1'b0;
   endtask

   task automatic wreg(input logic [2:0] idx, input logic [31:0] d);
      @(negedge clk);
      xl_valid    = 1'b0;
      cfg_wr_en   = 1'b1;
      cfg_wr_idx  = idx;
      cfg_wr_data = d;
      @(negedge clk);
      cfg_wr_en   = 1'b0;
   endtask

   task automatic report();
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (30000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R6 watchdog expired (got hang, expected completion)");
         report();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs idle during reset
      checks++;
      if (res_valid !== 1'b0 || res_miss !== 1'b0) begin
         errors++;
         $display("FAIL R1 valid=%b miss=%b expected 0 0", res_valid, res_miss);
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (res_valid !== 1'b0 || res_miss !== 1'b0) begin
         errors++;
         $display("FAIL R1 after reset valid=%b miss=%b expected 0 0", res_valid, res_miss);
      end

      // R2 / R12: window 0 base, interior, limit; back-to-back stream
      send(32'h01F0_0000, 64'h0100_0000, 5'd4, 1'b0, "R2_base");
      send(32'h01F1_2344, 64'h0101_2344, 5'd4, 1'b0, "R2_mid");
      send(32'h01F3_FFFF, 64'h0103_FFFF, 5'd4, 1'b0, "R12_limit");
      // R3: type 1 windows for buses 2..4
      send(32'h01F4_0000, 64'h0200_0000, 5'd5, 1'b0, "R3_bus2");
      send(32'h01F8_0010, 64'h0300_0010, 5'd5, 1'b0, "R3_bus3");
      send(32'h01FC_0100, 64'h0400_0100, 5'd5, 1'b0, "R3_bus4");
      quiet();
      // R4: shortened last window
      send(32'h01FF_BFFF, 64'h0403_BFFF, 5'd5, 1'b0, "R4_last_in");
      quiet();
      send(32'h01FF_C000, 64'h01FF_C000, 5'd0, 1'b1, "R4_hole_miss");
      // R12 / R5: just below aperture and far outside
      send(32'h01EF_FFFF, 64'h01EF_FFFF, 5'd0, 1'b1, "R12_below");
      send(32'h0000_1000, 64'h0000_1000, 5'd0, 1'b1, "R5_outside");
      quiet();

      // R7: retarget window 2 with 64-bit target and type 0
      wreg(3'd0, 32'd2);
      wreg(3'd6, 32'h0728_0000);
      wreg(3'd7, 32'h0000_0001);
      wreg(3'd1, 32'd4);
      send(32'h01F8_0004, 64'h1_0728_0004, 5'd4, 1'b0, "R7_retarget");
      quiet();

      // R8: disable window 1
      wreg(3'd0, 32'd1);
      wreg(3'd2, 32'h0000_0000);
      send(32'h01F4_0000, 64'h01F4_0000, 5'd0, 1'b1, "R8_disabled");
      quiet();

      // R9: window 3 widened over whole aperture
      wreg(3'd0, 32'd3);
      wreg(3'd3, 32'h01F0_0000);
      wreg(3'd5, 32'h01FF_FFFF);
      wreg(3'd6, 32'h0900_0000);
      send(32'h01F0_0008, 64'h0100_0008, 5'd4, 1'b0, "R9_low_wins");
      send(32'h01F4_0008, 64'h0904_0008, 5'd5, 1'b0, "R9_fallthrough");
      send(32'h01FF_F000, 64'h090F_F000, 5'd5, 1'b0, "R9_new_limit");
      quiet();

      // R10: selector out of range, writes must be dropped
      wreg(3'd0, 32'd4);
      wreg(3'd2, 32'h0000_0000);
      wreg(3'd3, 32'h0000_0000);
      wreg(3'd6, 32'hDEAD_0000);
      send(32'h01F0_0008, 64'h0100_0008, 5'd4, 1'b0, "R10_ignored_w0");
      send(32'h01FF_F000, 64'h090F_F000, 5'd5, 1'b0, "R10_ignored_w3");
      quiet();

      // R11: nonzero base high removes window 0
      wreg(3'd0, 32'd0);
      wreg(3'd4, 32'h0000_0001);
      send(32'h01F0_0008, 64'h0900_0008, 5'd5, 1'b0, "R11_basehi");
      quiet();

      repeat (4) @(negedge clk);
      // R6: every input produced its result
      checks++;
      if (queue_q.size() != 0) begin
         errors++;
         $display("FAIL R6 pending=%0d expected 0", queue_q.size());
      end
      done = 1'b1;
      report();
   end

endmodule